// File: doc/BRIEF.md
# Strided and Circular DMA Address Sequencer

This block produces the word addresses for a single DMA channel. A start strobe captures a base word address, a words-per-line count, a line pitch and a line count. The block then hands out one address per beat on a valid/ready handshake. In the strided two-dimensional mode it walks line by line. Each line begins one pitch after the start of the line before it. After the final word of the final line it pulses a completion flag once and returns to idle.

The circular mode is selected by a words-per-line count of zero together with the loop flag. In this mode the block sweeps a linear window whose size is the pitch times the line count. At the end of the window it wraps back to the base. It raises a one-cycle event each time the sweep finishes either half of the window. A circular transfer never completes and ends only on an abort. Every count and address is in units of 32-bit words. The bus protocol and data movement belong to the surrounding channel logic.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is asserted, and after it until the first start, `beat_valid`, `done_pulse` and `half_irq` are all low.
- R2: In strided mode the block issues (`cfg_ycnt`+1) lines of `cfg_xcnt` words. Word x of line y has the address `cfg_base` + y·`cfg_stride` + x, and words are issued line by line in ascending x.
- R3: The address and `beat_valid` stay unchanged in every cycle where `beat_valid` is high and `beat_ready` is low. The sequence advances by one entry only in a cycle where both are high.
- R4: In strided mode `done_pulse` is high for exactly one cycle, the cycle after the final beat is accepted. `beat_valid` is low in that cycle.
- R5: A start with `cfg_xcnt` = 0 and `cfg_loop` = 1 selects circular mode. The addresses run `cfg_base`, `cfg_base`+1, … up to `cfg_base` + R − 1, where R = `cfg_stride`·(`cfg_ycnt`+1), and then wrap back to `cfg_base`. `done_pulse` never rises in this mode.
- R6: In circular mode `half_irq` is high for one cycle in the cycle after a beat at offset floor(R/2) − 1 is accepted. It is also high for one cycle in the cycle after a beat at offset R − 1 is accepted. It is low in every other cycle.
- R7: A start is acted on only when the block is idle. A start while running, or in the completion cycle, changes neither the address sequence nor the captured configuration.
- R8: An abort makes `beat_valid`, `done_pulse` and `half_irq` low from the next cycle on, and the block returns to idle. An abort in the same cycle as a start wins over the start.
- R9: A start with `cfg_xcnt` = 0 and `cfg_loop` = 0 issues no beats. It gives a single `done_pulse` in the cycle after the start.
- R10: With `cfg_xcnt` nonzero the loop flag is ignored, and the transfer runs in strided mode as in R2 and R4.
- R11: With `cfg_xcnt` equal to `cfg_stride`, the strided output is one unbroken run of `cfg_xcnt`·(`cfg_ycnt`+1) consecutive addresses from `cfg_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, captures the configuration when idle |
| abort | input | 1 | Abort strobe, returns the block to idle |
| cfg_base | input | AW | Base word address |
| cfg_xcnt | input | LW | Words per line; zero selects circular or empty transfer |
| cfg_stride | input | LW | Line pitch in words (window size factor in circular mode) |
| cfg_ycnt | input | LW | Number of lines minus one |
| cfg_loop | input | 1 | Loop flag, used only when `cfg_xcnt` is zero |
| beat_valid | output | 1 | An address is offered |
| beat_ready | input | 1 | The offered address is taken this cycle |
| beat_addr | output | AW | Current word address |
| done_pulse | output | 1 | One-cycle completion of a strided transfer |
| half_irq | output | 1 | One-cycle half-window event in circular mode |

## Verification
A strided pattern with a pitch larger than the line length shows whether the gap between lines is skipped correctly. A pattern with pitch equal to line length must give a single unbroken run, so a wrong line-step offset shows up there. A window of even size and one of odd size separate a correct midpoint event from an off-by-one in the halving. Random back-pressure, starts during a run, and aborts in the middle of a line or of a sweep show whether the sequence advances only on accepted beats and whether stray strobes leave it alone.

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_xcnt,
  input  logic [LW-1:0] cfg_stride,
  input  logic [LW-1:0] cfg_ycnt,
  input  logic          cfg_loop,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] beat_addr,
  output logic          done_pulse,
  output logic          half_irq
);
  localparam int RW = 2 * LW + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t           st_q;
  logic [AW-1:0] base_q, line_q, addr_q;
  logic [LW-1:0] xlen_q, stride_q, ylen_q, xi_q, yi_q;
  logic [RW-1:0] pos_q, region_q, half_q;
  logic          loop_q, irq_q;

  wire           loop_sel = cfg_loop && (cfg_xcnt == '0);
  wire           empty_sel = !cfg_loop && (cfg_xcnt == '0);
  wire [LW:0]    lines_n = {1'b0, cfg_ycnt} + (LW+1)'(1);
  wire [RW-1:0]  region_n = RW'(cfg_stride) * RW'(lines_n);
  wire           last_x = (xi_q == xlen_q - LW'(1));
  wire           last_y = (yi_q == ylen_q);
  wire [RW-1:0]  pos_nx = pos_q + RW'(1);
  wire           wrap = (pos_nx == region_q);
  wire [AW-1:0]  next_line = line_q + AW'(stride_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      base_q   <= '0;
      line_q   <= '0;
      addr_q   <= '0;
      xlen_q   <= '0;
      stride_q <= '0;
      ylen_q   <= '0;
      xi_q     <= '0;
      yi_q     <= '0;
      pos_q    <= '0;
      region_q <= '0;
      half_q   <= '0;
      loop_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (abort) begin
        st_q <= S_IDLE;
      end else begin
        case (st_q)
          S_IDLE: if (start) begin
            base_q   <= cfg_base;
            line_q   <= cfg_base;
            addr_q   <= cfg_base;
            xlen_q   <= cfg_xcnt;
            stride_q <= cfg_stride;
            ylen_q   <= cfg_ycnt;
            xi_q     <= '0;
            yi_q     <= '0;
            pos_q    <= '0;
            region_q <= region_n;
            half_q   <= region_n >> 1;
            loop_q   <= loop_sel;
            st_q     <= empty_sel ? S_DONE : S_RUN;
          end
          S_RUN: if (beat_ready) begin
            if (loop_q) begin
              irq_q  <= wrap || (pos_nx == half_q);
              pos_q  <= wrap ? '0 : pos_nx;
              addr_q <= wrap ? base_q : addr_q + AW'(1);
            end else if (last_x) begin
              xi_q <= '0;
              if (last_y) begin
                st_q <= S_DONE;
              end else begin
                yi_q   <= yi_q + LW'(1);
                line_q <= next_line;
                addr_q <= next_line;
              end
            end else begin
              xi_q   <= xi_q + LW'(1);
              addr_q <= addr_q + AW'(1);
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign beat_valid = (st_q == S_RUN);
  assign beat_addr  = addr_q;
  assign done_pulse = (st_q == S_DONE);
  assign half_irq   = irq_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] beat_addr,
  input logic          done_pulse,
  input logic          half_irq
);
  assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready && !abort) |=> (beat_valid && $stable(beat_addr)));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !beat_valid);

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!beat_valid && !done_pulse && !half_irq));

  assert_irq_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    half_irq |-> $past(beat_valid && beat_ready));

  assert_irq_not_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    half_irq |-> !done_pulse);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .beat_addr(beat_addr), .done_pulse(done_pulse),
  .half_irq(half_irq)
);

// File: tb/dma2d_addr_gen_bench.sv
module dma2d_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0, ready = 1'b0, c_loop = 1'b0;
  logic [31:0] c_base = '0;
  logic [15:0] c_x = '0, c_stride = '0, c_y = '0;
  logic        valid, done, irq;
  logic [31:0] addr;

  always #4 clk = ~clk;

  dma2d_addr_gen u_dma2d_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_base(c_base), .cfg_xcnt(c_x), .cfg_stride(c_stride), .cfg_ycnt(c_y),
    .cfg_loop(c_loop), .beat_valid(valid), .beat_ready(ready),
    .beat_addr(addr), .done_pulse(done), .half_irq(irq)
  );

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  bit          m_run = 0, m_done = 0, m_irq = 0, m_loop = 0;
  logic [31:0] q[$];
  logic [31:0] m_base;
  int          m_pos, m_region, m_half;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input bit st, input bit ab, input bit rd);
    logic [31:0] ea;
    bit done_now;
    start = st; abort = ab; ready = rd;
    #1;
    chk(valid === m_run, cur_req, "valid", 32'(valid), 32'(m_run));
    if (m_run) begin
      ea = m_loop ? m_base + 32'(m_pos) : q[0];
      chk(addr === ea, cur_req, "addr", addr, ea);
    end
    chk(done === m_done, "R4", "done", 32'(done), 32'(m_done));
    chk(irq === m_irq, "R6", "half_irq", 32'(irq), 32'(m_irq));
    done_now = m_done;
    m_done = 0; m_irq = 0;
    if (ab) begin
      m_run = 0; q.delete();
    end else if (m_run && rd) begin
      if (m_loop) begin
        m_irq = (m_pos + 1 == m_half) || (m_pos + 1 == m_region);
        m_pos = (m_pos + 1 == m_region) ? 0 : m_pos + 1;
      end else begin
        void'(q.pop_front());
        if (q.size() == 0) begin m_run = 0; m_done = 1; end
      end
    end else if (!m_run && !done_now && st) begin
      if (c_x == 0 && c_loop) begin
        m_loop = 1; m_run = 1; m_base = c_base; m_pos = 0;
        m_region = int'(c_stride) * (int'(c_y) + 1);
        m_half = m_region / 2;
      end else if (c_x == 0) begin
        m_done = 1;
      end else begin
        m_loop = 0; m_run = 1;
        for (int y = 0; y <= int'(c_y); y++)
          for (int x = 0; x < int'(c_x); x++)
            q.push_back(c_base + 32'(y) * 32'(c_stride) + 32'(x));
      end
    end
    @(negedge clk);
  endtask

  task automatic cfg(input logic [31:0] b, input int x, input int s, input int y, input bit lp);
    c_base = b; c_x = 16'(x); c_stride = 16'(s); c_y = 16'(y); c_loop = lp;
  endtask

  task automatic drain(input bit rnd);
    while (m_run || m_done) tick(0, 0, rnd ? 1'($urandom_range(0, 1)) : 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!valid && !done && !irq, "R1", "reset outputs", {valid, done, irq}, 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    tick(0, 0, 1); tick(0, 0, 1);

    cur_req = "R2"; cfg(32'h100, 3, 5, 2, 0);
    tick(1, 0, 1); drain(0); tick(0, 0, 1);

    cur_req = "R11"; cfg(32'h2000, 4, 4, 3, 0);
    tick(1, 0, 1); drain(0); tick(0, 0, 1);

    cur_req = "R3"; cfg(32'h3000, 2, 7, 3, 0);
    tick(1, 0, 0); drain(1); tick(0, 0, 1);

    cur_req = "R7"; cfg(32'h500, 5, 8, 1, 0);
    tick(1, 0, 1); tick(0, 0, 1); tick(0, 0, 0);
    cfg(32'h9000, 1, 1, 0, 0);
    tick(1, 0, 1); tick(1, 0, 0);
    while (m_run) tick(0, 0, 1);
    tick(1, 0, 1);
    tick(0, 0, 1);

    cur_req = "R8"; cfg(32'h700, 4, 6, 3, 0);
    tick(1, 0, 1); tick(0, 0, 1); tick(0, 0, 1); tick(0, 0, 1);
    tick(0, 1, 1); tick(0, 0, 1); tick(1, 1, 1); tick(0, 0, 1);

    cur_req = "R5"; cfg(32'h40, 0, 4, 1, 1);
    tick(1, 0, 1);
    for (int i = 0; i < 20; i++) tick(0, 0, 1);
    tick(0, 1, 1); tick(0, 0, 1);

    cur_req = "R6"; cfg(32'h80, 0, 3, 0, 1);
    tick(1, 0, 1);
    for (int i = 0; i < 15; i++) tick(0, 0, 1'($urandom_range(0, 1)));
    tick(0, 1, 0); tick(0, 0, 1);

    cur_req = "R9"; cfg(32'hA0, 0, 3, 2, 0);
    tick(1, 0, 1); tick(0, 0, 1); tick(0, 0, 1);

    cur_req = "R10"; cfg(32'hC0, 2, 3, 1, 1);
    tick(1, 0, 1); drain(1); tick(0, 0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule